// File: doc/BRIEF.md
# Loop-Nest Address Generator

This block turns a small per-layer table of nested loop counts and per-loop strides into a stream of buffer addresses. Before a layer runs, a sequence of configuration entries is written into it. A setup entry opens the layer and records its operand precision code. Base entries give the start address of the input, output and weight buffers. Loop entries define the nest of counters, each with an ID. Stride entries bind a signed stride to a loop ID for one buffer. An end entry carries the address of the next program block.

After `start`, the block steps through every combination of loop indices, one combination per clock. The innermost counter moves on every step. For each step it presents three addresses: for each buffer, the base plus the sum over loops of stride times that loop's current index. When the outermost loop wraps, it pulses `done` and shows the next-block address. The table is loaded once and reused for the whole walk. Fetching the entries and accessing memory are outside this block.

The controller has three states. In `S_IDLE` the block accepts configuration and waits for `start`; the transition `S_IDLE -> S_RUN` is taken when `start` is seen. In `S_RUN` one address triple is issued per cycle; `S_RUN -> S_DONE` is taken on the step where every loaded counter sits at its last value. `S_DONE` lasts one cycle, with `done` high, and then takes `S_DONE -> S_IDLE`.

Top module: `loop_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `done`, `next_blk` and `prec_cfg` are all zero.
- R2: An entry with `cfg_kind` = 0 (setup) removes all loops, zeroes all strides and bases, and places `cfg_data[7:0]` on `prec_cfg`.
- R3: An entry with `cfg_kind` = 1 (base) stores `cfg_data` as the base of the buffer chosen by `cfg_buf` (0 input, 1 output, 2 weight). `cfg_buf` = 3 changes nothing.
- R4: An entry with `cfg_kind` = 2 (loop) appends a loop with ID `cfg_sel` and iteration count `cfg_data[15:0]`. The first loop loaded is the outermost. A count of 0 behaves like 1. Loop entries beyond the sixteenth are ignored.
- R5: An entry with `cfg_kind` = 3 (stride) adds the signed value `cfg_data[15:0]` to the stride of loop ID `cfg_sel` for buffer `cfg_buf`. Repeated entries for the same pair accumulate. Strides bound to an ID that no loaded loop carries contribute nothing.
- R6: An entry with `cfg_kind` = 4 (end) places `cfg_data` on `next_blk`.
- R7: A `start` in idle makes `addr_valid` high on the next cycle. After that, one step is issued per cycle: the innermost index advances each step, and a counter that reaches its last value wraps to 0 and carries one into the next outer loop.
- R8: On each valid step, each address equals that buffer's base plus the sum of stride times current index over the loaded loops, modulo 2^32.
- R9: The number of steps equals the product of the loop counts (one step when no loop is loaded). On the cycle after the last step, `done` is high for exactly one cycle and `addr_valid` is low.
- R10: While steps are being issued, configuration writes and `start` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration entry strobe |
| cfg_kind | input | 3 | Entry kind (0 setup, 1 base, 2 loop, 3 stride, 4 end) |
| cfg_sel | input | 4 | Loop ID for loop and stride entries |
| cfg_buf | input | 2 | Buffer select for base and stride entries |
| cfg_data | input | 32 | Entry payload |
| start | input | 1 | Begin the walk |
| addr_valid | output | 1 | An address triple is presented |
| in_addr | output | 32 | Input buffer address |
| out_addr | output | 32 | Output buffer address |
| wgt_addr | output | 32 | Weight buffer address |
| done | output | 1 | One-cycle pulse after the last step |
| next_blk | output | 32 | Next program block address |
| prec_cfg | output | 8 | Precision code from the setup entry |

## Verification
The bench targets these corner cases, and what a faulty design would do in each:
- **Carry chain across three levels with mixed-sign strides.** An off-by-one wrap would repeat or skip an index combination and give a wrong address at the seam between iterations.
- **Address wrap modulo 2^32.** A negative stride pushes the output address below zero; narrowed arithmetic would give a wrong wrapped value.
- **A zero count and an empty nest.** A design that treats 0 literally would hang or issue nothing; an empty nest must still emit exactly the bases once.
- **Extra entries.** Duplicated stride entries must add up. A seventeenth loop and a base write to select 3 must have no effect, or the step count or addresses shift.
- **Writes and `start` arriving mid-walk.** A leaky design would change addresses partway through or restart the count.

// File: rtl/lag_pkg.sv
package lag_pkg;
    localparam int ADDR_W   = 32;
    localparam int STRIDE_W = 16;
    localparam int CNT_W    = 16;
    localparam int LOOPS    = 16;
    localparam int ID_W     = 4;
    localparam int NBUF     = 3;
    localparam int PREC_W   = 8;

    typedef enum logic [2:0] {
        K_SETUP  = 3'd0,
        K_BASE   = 3'd1,
        K_LOOP   = 3'd2,
        K_STRIDE = 3'd3,
        K_END    = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } state_e;
endpackage

// File: rtl/lag_cfg_store.sv
module lag_cfg_store
    import lag_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int SW    = STRIDE_W,
    parameter int CW    = CNT_W,
    parameter int NL    = LOOPS,
    parameter int IW    = ID_W,
    parameter int NB    = NBUF,
    parameter int PW    = PREC_W,
    localparam int NID  = 1 << IW,
    localparam int LW   = $clog2(NL),
    localparam int LCW  = $clog2(NL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    kind,
    input  logic [IW-1:0] sel,
    input  logic [1:0]    buf_sel,
    input  logic [AW-1:0] data,
    output logic [AW-1:0] base   [NB],
    output logic [AW-1:0] stride [NB][NID],
    output logic [CW-1:0] lim    [NL],
    output logic [IW-1:0] lid    [NL],
    output logic [LCW-1:0] nloops,
    output logic [PW-1:0] prec,
    output logic [AW-1:0] next_blk
);
    logic [AW-1:0] sx_data;
    assign sx_data = {{(AW-SW){data[SW-1]}}, data[SW-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nloops   <= '0;
            prec     <= '0;
            next_blk <= '0;
            for (int b = 0; b < NB; b++) begin
                base[b] <= '0;
                for (int i = 0; i < NID; i++) stride[b][i] <= '0;
            end
            for (int l = 0; l < NL; l++) begin
                lim[l] <= '0;
                lid[l] <= '0;
            end
        end else if (wr_en) begin
            case (kind_e'(kind))
                K_SETUP: begin
                    nloops <= '0;
                    prec   <= data[PW-1:0];
                    for (int b = 0; b < NB; b++) begin
                        base[b] <= '0;
                        for (int i = 0; i < NID; i++) stride[b][i] <= '0;
                    end
                    for (int l = 0; l < NL; l++) begin
                        lim[l] <= '0;
                        lid[l] <= '0;
                    end
                end
                K_BASE: begin
                    if (int'(buf_sel) < NB) base[buf_sel] <= data;
                end
                K_LOOP: begin
                    if (int'(nloops) < NL) begin
                        lim[nloops[LW-1:0]] <= data[CW-1:0];
                        lid[nloops[LW-1:0]] <= sel;
                        nloops <= nloops + 1'b1;
                    end
                end
                K_STRIDE: begin
                    if (int'(buf_sel) < NB)
                        stride[buf_sel][sel] <= stride[buf_sel][sel] + sx_data;
                end
                K_END: next_blk <= data;
                default: ;
            endcase
        end
    end

    // R2: a setup entry leaves the loop nest empty
    a_r2_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_SETUP) |=> (nloops == '0));

    // R4: the nest never holds more loops than its capacity
    a_r4_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        int'(nloops) <= NL);
endmodule

// File: rtl/lag_loop_nest.sv
module lag_loop_nest
    import lag_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int NL   = LOOPS,
    localparam int LCW = $clog2(NL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic [LCW-1:0] nloops,
    input  logic [CW-1:0]  lim [NL],
    output logic [CW-1:0]  idx [NL],
    output logic           last
);
    logic [NL-1:0] at_max;
    logic [NL:0]   carry;
    logic          any_nz;

    assign carry[NL] = step;

    generate
        for (genvar l = 0; l < NL; l++) begin : g_lvl
            assign at_max[l] = (l >= int'(nloops)) || (lim[l] <= CW'(1)) ||
                               (idx[l] == lim[l] - CW'(1));
            assign carry[l]  = carry[l+1] & at_max[l];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    idx[l] <= '0;
                else if (carry[l+1])
                    idx[l] <= at_max[l] ? '0 : idx[l] + CW'(1);
            end

            // R7: an index never reaches its iteration count
            a_r7_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
                (idx[l] == '0) || (idx[l] < lim[l]));
        end
    endgenerate

    assign last = carry[0];

    always_comb begin
        any_nz = 1'b0;
        for (int l = 0; l < NL; l++) any_nz = any_nz | (|idx[l]);
    end

    // R7: the final step returns every counter to zero
    a_r7_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !any_nz);
endmodule

// File: rtl/lag_addr_sum.sv
module lag_addr_sum
    import lag_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int CW   = CNT_W,
    parameter int NL   = LOOPS,
    parameter int IW   = ID_W,
    localparam int NID = 1 << IW,
    localparam int LCW = $clog2(NL + 1)
) (
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  stride [NID],
    input  logic [IW-1:0]  lid    [NL],
    input  logic [CW-1:0]  idx    [NL],
    input  logic [LCW-1:0] nloops,
    output logic [AW-1:0]  addr
);
    always_comb begin
        addr = base;
        for (int l = 0; l < NL; l++) begin
            if (l < int'(nloops))
                addr = addr + stride[lid[l]] * AW'(idx[l]);
        end
    end
endmodule

// File: rtl/loop_addr_gen.sv
module loop_addr_gen
    import lag_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int SW   = STRIDE_W,
    parameter int CW   = CNT_W,
    parameter int NL   = LOOPS,
    parameter int IW   = ID_W,
    parameter int PW   = PREC_W,
    localparam int NB  = NBUF,
    localparam int NID = 1 << IW,
    localparam int LCW = $clog2(NL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_kind,
    input  logic [IW-1:0] cfg_sel,
    input  logic [1:0]    cfg_buf,
    input  logic [AW-1:0] cfg_data,
    input  logic          start,
    output logic          addr_valid,
    output logic [AW-1:0] in_addr,
    output logic [AW-1:0] out_addr,
    output logic [AW-1:0] wgt_addr,
    output logic          done,
    output logic [AW-1:0] next_blk,
    output logic [PW-1:0] prec_cfg
);
    state_e         state_q, state_d;
    logic           step, last, accept;
    logic [AW-1:0]  base   [NB];
    logic [AW-1:0]  stride [NB][NID];
    logic [CW-1:0]  lim    [NL];
    logic [IW-1:0]  lid    [NL];
    logic [CW-1:0]  idx    [NL];
    logic [LCW-1:0] nloops;
    logic [AW-1:0]  addr   [NB];

    assign step   = (state_q == S_RUN);
    assign accept = cfg_we && (state_q != S_RUN);

    lag_cfg_store #(.AW(AW), .SW(SW), .CW(CW), .NL(NL), .IW(IW), .NB(NB), .PW(PW)) u_cfg (
        .clk, .rst_n,
        .wr_en(accept), .kind(cfg_kind), .sel(cfg_sel), .buf_sel(cfg_buf), .data(cfg_data),
        .base, .stride, .lim, .lid, .nloops, .prec(prec_cfg), .next_blk
    );

    lag_loop_nest #(.CW(CW), .NL(NL)) u_nest (
        .clk, .rst_n, .step, .nloops, .lim, .idx, .last
    );

    generate
        for (genvar b = 0; b < NB; b++) begin : g_buf
            lag_addr_sum #(.AW(AW), .CW(CW), .NL(NL), .IW(IW)) u_sum (
                .base(base[b]), .stride(stride[b]), .lid, .idx, .nloops, .addr(addr[b])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_RUN;
            S_RUN:   if (last)  state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        addr_valid = (state_q == S_RUN);
        done       = (state_q == S_DONE);
        in_addr    = addr[0];
        out_addr   = addr[1];
        wgt_addr   = addr[2];
    end

    // R9: done lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: start from idle launches the walk next cycle
    a_r7_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start) |=> addr_valid);

    // R9: steps continue until the nest reports its final step
    a_r9_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !last) |=> addr_valid);

    // R10: the configuration stays frozen during a walk
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> ($stable(prec_cfg) && $stable(next_blk)));
endmodule

// File: tb/tb_loop_addr_gen.sv
`timescale 1ns/1ps
module tb_loop_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_kind = '0;
    logic [3:0]  cfg_sel = '0;
    logic [1:0]  cfg_buf = '0;
    logic [31:0] cfg_data = '0;
    logic        start = 1'b0;
    logic        addr_valid, done;
    logic [31:0] in_addr, out_addr, wgt_addr, next_blk;
    logic [7:0]  prec_cfg;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    loop_addr_gen dut (
        .clk, .rst_n, .cfg_we, .cfg_kind, .cfg_sel, .cfg_buf, .cfg_data, .start,
        .addr_valid, .in_addr, .out_addr, .wgt_addr, .done, .next_blk, .prec_cfg
    );

    typedef struct packed {
        logic [3:0]  n;
        logic [15:0] c0, c1, c2;
        logic [15:0] si0, si1, si2;
        logic [15:0] so0, so1, so2;
        logic [15:0] sw0, sw1, sw2;
        logic [31:0] bi, bo, bw;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{n:4'd3, c0:16'd2, c1:16'd3, c2:16'd2,
          si0:16'd100, si1:16'd10, si2:16'd1,
          so0:16'd0, so1:16'd4, so2:-16'sd4,
          sw0:-16'sd8, sw1:16'd0, sw2:16'd2,
          bi:32'd1000, bo:32'd2000, bw:32'd16},
        '{n:4'd1, c0:16'd5, c1:16'd3, c2:16'd3,
          si0:16'd3, si1:16'd50, si2:16'd70,
          so0:-16'sd1, so1:16'd9, so2:16'd9,
          sw0:16'd0, sw1:16'd11, sw2:16'd13,
          bi:32'd0, bo:32'd2, bw:32'hFFFF_FFF0},
        '{n:4'd2, c0:16'd0, c1:16'd4, c2:16'd2,
          si0:16'd7, si1:16'd1, si2:16'd500,
          so0:16'd0, so1:-16'sd300, so2:16'd5,
          sw0:16'd1000, sw1:-16'sd2, sw2:16'd6,
          bi:32'd10, bo:32'd20, bw:32'd30},
        '{n:4'd0, c0:16'd4, c1:16'd4, c2:16'd4,
          si0:16'd1, si1:16'd2, si2:16'd3,
          so0:16'd4, so1:16'd5, so2:16'd6,
          sw0:16'd7, sw1:16'd8, sw2:16'd9,
          bi:32'd5, bo:32'd6, bw:32'd7}
    };

    localparam logic [3:0] IDS [3] = '{4'd5, 4'd2, 4'd9};

    function automatic logic [31:0] sx(input logic [15:0] s);
        return {{16{s[15]}}, s};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] k, input logic [3:0] s, input logic [1:0] b,
                      input logic [31:0] d);
        cfg_we = 1'b1; cfg_kind = k; cfg_sel = s; cfg_buf = b; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic program_vec(input vec_t v, input int k);
        logic [15:0] cnt [3];
        logic [15:0] st  [3][3];
        cnt = '{v.c0, v.c1, v.c2};
        st  = '{'{v.si0, v.si1, v.si2}, '{v.so0, v.so1, v.so2}, '{v.sw0, v.sw1, v.sw2}};
        wr(3'd0, 4'd0, 2'd0, 32'(8'h30 + k));
        wr(3'd1, 4'd0, 2'd0, v.bi);
        wr(3'd1, 4'd0, 2'd1, v.bo);
        wr(3'd1, 4'd0, 2'd2, v.bw);
        for (int l = 0; l < int'(v.n); l++) wr(3'd2, IDS[l], 2'd0, {16'd0, cnt[l]});
        for (int b = 0; b < 3; b++)
            for (int l = 0; l < 3; l++) wr(3'd3, IDS[l], 2'(b), {16'd0, st[b][l]});
        wr(3'd4, 4'd0, 2'd0, 32'h4000 + 32'(k * 16));
    endtask

    task automatic run_vec(input vec_t v, input int k);
        int e [3];
        logic [31:0] s [3][3];
        logic [31:0] ex [3];
        logic [15:0] cnt [3];
        cnt = '{v.c0, v.c1, v.c2};
        for (int l = 0; l < 3; l++) begin
            e[l] = (l < int'(v.n)) ? ((cnt[l] == 0) ? 1 : int'(cnt[l])) : 1;
        end
        s[0] = '{sx(v.si0), sx(v.si1), sx(v.si2)};
        s[1] = '{sx(v.so0), sx(v.so1), sx(v.so2)};
        s[2] = '{sx(v.sw0), sx(v.sw1), sx(v.sw2)};
        for (int l = 0; l < 3; l++)
            if (l >= int'(v.n)) begin s[0][l] = 0; s[1][l] = 0; s[2][l] = 0; end
        pulse_start();
        for (int a = 0; a < e[0]; a++)
            for (int b = 0; b < e[1]; b++)
                for (int c = 0; c < e[2]; c++) begin
                    ex[0] = v.bi + s[0][0]*32'(a) + s[0][1]*32'(b) + s[0][2]*32'(c);
                    ex[1] = v.bo + s[1][0]*32'(a) + s[1][1]*32'(b) + s[1][2]*32'(c);
                    ex[2] = v.bw + s[2][0]*32'(a) + s[2][1]*32'(b) + s[2][2]*32'(c);
                    chk("R7 valid during walk", 32'(addr_valid), 32'd1);
                    chk("R8 input address", in_addr, ex[0]);
                    chk("R8 output address", out_addr, ex[1]);
                    chk("R8 weight address", wgt_addr, ex[2]);
                    @(negedge clk);
                end
        chk("R9 done after last step", 32'(done), 32'd1);
        chk("R9 valid low at done", 32'(addr_valid), 32'd0);
        chk("R6 next block address", next_blk, 32'h4000 + 32'(k * 16));
        chk("R2 precision code", 32'(prec_cfg), 32'(8'h30 + k));
        @(negedge clk);
        chk("R9 done is one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 addr_valid", 32'(addr_valid), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 next_blk", next_blk, 32'd0);
        chk("R1 prec_cfg", 32'(prec_cfg), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R4 R5 R7 R8 R9
        for (int k = 0; k < 4; k++) begin
            program_vec(VECS[k], k);
            run_vec(VECS[k], k);
        end

        // R5 accumulation, R3 select 3 ignored
        wr(3'd0, 4'd0, 2'd0, 32'd1);
        wr(3'd2, 4'd3, 2'd0, 32'd3);
        wr(3'd3, 4'd3, 2'd0, 32'd5);
        wr(3'd3, 4'd3, 2'd0, 32'd5);
        wr(3'd1, 4'd0, 2'd3, 32'd999);
        pulse_start();
        for (int i = 0; i < 3; i++) begin
            chk("R5 summed stride", in_addr, 32'(10 * i));
            chk("R3 select 3 no effect out", out_addr, 32'd0);
            chk("R3 select 3 no effect wgt", wgt_addr, 32'd0);
            @(negedge clk);
        end
        chk("R9 done after 3 steps", 32'(done), 32'd1);
        @(negedge clk);

        // R10 writes and start ignored during a walk
        wr(3'd0, 4'd0, 2'd0, 32'd2);
        wr(3'd1, 4'd0, 2'd0, 32'd100);
        wr(3'd2, 4'd1, 2'd0, 32'd4);
        wr(3'd3, 4'd1, 2'd0, 32'd1);
        pulse_start();
        for (int i = 0; i < 4; i++) begin
            chk("R10 address unaffected", in_addr, 32'(100 + i));
            chk("R10 still valid", 32'(addr_valid), 32'd1);
            if (i == 1) begin
                cfg_we = 1'b1; cfg_kind = 3'd1; cfg_buf = 2'd0; cfg_data = 32'd5000;
                start = 1'b1;
            end else begin
                cfg_we = 1'b0; start = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0; start = 1'b0;
        chk("R10 step count kept", 32'(done), 32'd1);
        @(negedge clk);
        pulse_start();
        chk("R10 base kept for rerun", in_addr, 32'd100);
        repeat (4) @(negedge clk);

        // R4 seventeenth loop ignored
        wr(3'd0, 4'd0, 2'd0, 32'd3);
        wr(3'd1, 4'd0, 2'd0, 32'd77);
        for (int l = 0; l < 16; l++) wr(3'd2, 4'(l), 2'd0, 32'd1);
        wr(3'd2, 4'd7, 2'd0, 32'd9);
        wr(3'd3, 4'd7, 2'd0, 32'd1);
        pulse_start();
        chk("R4 single step", in_addr, 32'd77);
        @(negedge clk);
        chk("R4 extra loop ignored", 32'(done), 32'd1);
        chk("R4 no second step", 32'(addr_valid), 32'd0);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule